// File: doc/BRIEF.md
# Transient Vector Instruction Prefix Controller

This block holds a one-shot prefix for the vector unit. A prefix instruction supplies 15 bits from its register specifier fields. When those bits are legal, the low 10 bits are stored in the prefix field of the vector type register, bits [30:21] of a 32-bit word. The prefix is then applied to the next vector instruction only. It is dropped when that instruction completes, faults or is interrupted.

The controller enforces strict adjacency. The prefix may only be followed by a vector instruction that supports a prefix. Any other successor is reported as a fault on the prefix instruction itself, with that instruction's PC as the exception PC. A vector instruction that cannot take a prefix is reported as a fault on that vector instruction.

When an interrupt hits the prefixed instruction, the controller does two things. It reports the prefix instruction's PC as the restart PC, so the prefix is executed again on return. It also records the element index at which execution should resume. The controller never decodes what the prefix means.

Top module: `vpfx_ctrl`

## Requirements
- R1: After reset, `pfx_o`, `vtype_pfx_o`, `exc_o`, `exc_cause_o`, `restart_o`, `epc_o` and `vstart_o` are all zero.
- R2: In the idle state, a prefix instruction is legal when source bits [14:10] are zero.
  - A legal prefix instruction stores source bits [9:0] and records its PC.
  - From the next cycle, `pfx_o` shows the stored prefix.
  - `vtype_pfx_o` carries the same value at bits [30:21] and zero in every other bit.
- R3: In the idle state, a prefix instruction with any nonzero bit in [14:10] raises `exc_o` for one cycle with `exc_cause_o` = 2'b01. No prefix is stored.
- R4: Once armed, a following instruction with `ins_vec_i`=1 and `ins_pfx_ok_i`=1 starts execution of the prefixed instruction.
  - `pfx_o` keeps the prefix while that instruction executes.
  - `pfx_o` becomes zero in the cycle after `ins_done_i`, provided no interrupt arrives in the same cycle.
- R5: While armed, two successors are treated as non-adjacent: an instruction with `ins_vec_i`=0, or a new prefix instruction (which takes priority over `ins_valid_i`).
  - A non-adjacent successor raises `exc_o` with cause 2'b10.
  - `epc_o` is loaded with the stored prefix PC.
  - The prefix is cleared.
- R6: While armed, a vector successor with `ins_pfx_ok_i`=0 raises `exc_o` with cause 2'b11. The prefix is cleared and `epc_o` is left unchanged.
- R7: An interrupt (`irq_i`) during the prefixed instruction wins over `ins_done_i` in the same cycle.
  - `restart_o` pulses for one cycle.
  - `epc_o` is loaded with the prefix PC.
  - `vstart_o` is loaded with `elem_idx_i`.
  - The prefix is cleared.
- R8: `vstart_o` changes only on a restart. Accepting a prefix and raising an exception leave it unchanged.
- R9: Some inputs have no effect on the outputs:
  - While armed, `irq_i` and `ins_done_i` are ignored.
  - While the prefixed instruction executes, `pfx_valid_i` and `ins_valid_i` are ignored.
- R10: `exc_o` and `restart_o` are single-cycle strobes and are never high together. `exc_cause_o` is zero whenever `exc_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pfx_valid_i | input | 1 | Prefix instruction issued this cycle |
| pfx_src_i | input | 15 | Specifier-field bits of the prefix instruction |
| pfx_pc_i | input | 32 | PC of the prefix instruction |
| ins_valid_i | input | 1 | Next instruction issued this cycle |
| ins_vec_i | input | 1 | That instruction is a vector instruction |
| ins_pfx_ok_i | input | 1 | That instruction accepts a prefix |
| ins_done_i | input | 1 | Prefixed instruction completes |
| irq_i | input | 1 | Interrupt taken during the prefixed instruction |
| elem_idx_i | input | 16 | Current element index of the prefixed instruction |
| pfx_o | output | 10 | Prefix presented to the vector datapath |
| vtype_pfx_o | output | 32 | Prefix placed in its vector-type field |
| exc_o | output | 1 | Exception strobe |
| exc_cause_o | output | 2 | Exception cause: 01 bad source, 10 non-adjacent, 11 unsupported |
| restart_o | output | 1 | Interrupt restart strobe |
| epc_o | output | 32 | Exception or restart PC |
| vstart_o | output | 16 | Resume element index |

## Verification
Directed sequences cover several paths, and each ends in a distinguishable way:
- an armed prefix consumed by a normal completion;
- a bad source word;
- a scalar successor;
- a second prefix;
- an unsupported vector target;
- an interrupt that coincides with completion.

Each path differs in the cause code, in whether `epc_o` moves, and in whether `vstart_o` moves. A stretch of seeded random traffic then mixes every input in every state, including inputs that should be ignored. Random prefix values tell apart stale and fresh prefixes. Random element indices and PCs show that `vstart_o` and `epc_o` are captured from the right cycle.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2
  } vpfx_state_e;

  localparam logic [1:0] CAUSE_NONE  = 2'b00;
  localparam logic [1:0] CAUSE_SRC   = 2'b01;
  localparam logic [1:0] CAUSE_ADJ   = 2'b10;
  localparam logic [1:0] CAUSE_UNSUP = 2'b11;
endpackage

// File: rtl/vpfx_src_chk.sv
module vpfx_src_chk #(
  parameter int SRC_W = 15,
  parameter int PFX_W = 10
) (
  input  logic [SRC_W-1:0] src_i,
  output logic [PFX_W-1:0] pfx_o,
  output logic             legal_o
);
  localparam int XTRA_W = SRC_W - PFX_W;

  generate
    if (XTRA_W > 0) begin : g_xtra
      assign legal_o = ~|src_i[SRC_W-1:PFX_W];
    end else begin : g_none
      assign legal_o = 1'b1;
    end
  endgenerate

  assign pfx_o = src_i[PFX_W-1:0];
endmodule

// File: rtl/vpfx_fsm.sv
module vpfx_fsm
  import vpfx_pkg::*;
#(
  parameter int PFX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pfx_valid_i,
  input  logic             src_legal_i,
  input  logic [PFX_W-1:0] src_pfx_i,
  input  logic             ins_valid_i,
  input  logic             ins_vec_i,
  input  logic             ins_pfx_ok_i,
  input  logic             ins_done_i,
  input  logic             irq_i,
  output vpfx_state_e      state_o,
  output logic [PFX_W-1:0] pfx_o,
  output logic             arm_o,
  output logic             epc_load_o,
  output logic             restart_o,
  output logic             exc_o,
  output logic [1:0]       exc_cause_o
);
  vpfx_state_e      state_q, state_d;
  logic [PFX_W-1:0] pfx_q, pfx_d;
  logic             exc_d, rst_d, epc_ld;
  logic [1:0]       cause_d;

  always_comb begin
    state_d = state_q;
    pfx_d   = pfx_q;
    exc_d   = 1'b0;
    rst_d   = 1'b0;
    cause_d = CAUSE_NONE;
    epc_ld  = 1'b0;
    arm_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pfx_valid_i) begin
          if (src_legal_i) begin
            state_d = ST_ARMED;
            pfx_d   = src_pfx_i;
            arm_o   = 1'b1;
          end else begin
            exc_d   = 1'b1;
            cause_d = CAUSE_SRC;
          end
        end
      end
      ST_ARMED: begin
        // a second prefix or a scalar successor breaks adjacency
        if (pfx_valid_i || (ins_valid_i && !ins_vec_i)) begin
          state_d = ST_IDLE;
          pfx_d   = '0;
          exc_d   = 1'b1;
          cause_d = CAUSE_ADJ;
          epc_ld  = 1'b1;
        end else if (ins_valid_i && !ins_pfx_ok_i) begin
          state_d = ST_IDLE;
          pfx_d   = '0;
          exc_d   = 1'b1;
          cause_d = CAUSE_UNSUP;
        end else if (ins_valid_i) begin
          state_d = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (irq_i) begin
          state_d = ST_IDLE;
          pfx_d   = '0;
          rst_d   = 1'b1;
          epc_ld  = 1'b1;
        end else if (ins_done_i) begin
          state_d = ST_IDLE;
          pfx_d   = '0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        pfx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pfx_q       <= '0;
      exc_o       <= 1'b0;
      exc_cause_o <= CAUSE_NONE;
      restart_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      pfx_q       <= pfx_d;
      exc_o       <= exc_d;
      exc_cause_o <= cause_d;
      restart_o   <= rst_d;
    end
  end

  assign epc_load_o = epc_ld;
  assign state_o    = state_q;
  assign pfx_o      = (state_q == ST_IDLE) ? '0 : pfx_q;
endmodule

// File: rtl/vpfx_ctx.sv
module vpfx_ctx #(
  parameter int PC_W     = 32,
  parameter int VSTART_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic [PC_W-1:0]     pc_i,
  input  logic                epc_load_i,
  input  logic                restart_i,
  input  logic [VSTART_W-1:0] elem_idx_i,
  output logic [PC_W-1:0]     epc_o,
  output logic [VSTART_W-1:0] vstart_o
);
  logic [PC_W-1:0] pfx_pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pfx_pc_q <= '0;
      epc_o    <= '0;
      vstart_o <= '0;
    end else begin
      if (arm_i)      pfx_pc_q <= pc_i;
      if (epc_load_i) epc_o    <= pfx_pc_q;
      if (restart_i)  vstart_o <= elem_idx_i;
    end
  end
endmodule

// File: rtl/vpfx_ctrl.sv
module vpfx_ctrl
  import vpfx_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int SRC_W    = 15,
  parameter int PFX_W    = 10,
  parameter int PFX_LSB  = 21,
  parameter int VSTART_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pfx_valid_i,
  input  logic [SRC_W-1:0]    pfx_src_i,
  input  logic [XLEN-1:0]     pfx_pc_i,
  input  logic                ins_valid_i,
  input  logic                ins_vec_i,
  input  logic                ins_pfx_ok_i,
  input  logic                ins_done_i,
  input  logic                irq_i,
  input  logic [VSTART_W-1:0] elem_idx_i,
  output logic [PFX_W-1:0]    pfx_o,
  output logic [XLEN-1:0]     vtype_pfx_o,
  output logic                exc_o,
  output logic [1:0]          exc_cause_o,
  output logic                restart_o,
  output logic [XLEN-1:0]     epc_o,
  output logic [VSTART_W-1:0] vstart_o
);
  localparam int PFX_MSB = PFX_LSB + PFX_W - 1;

  logic [PFX_W-1:0] src_pfx;
  logic             src_legal, arm, epc_load, rst_stb;
  vpfx_state_e      state;

  vpfx_src_chk #(.SRC_W(SRC_W), .PFX_W(PFX_W)) u_src (
    .src_i  (pfx_src_i),
    .pfx_o  (src_pfx),
    .legal_o(src_legal)
  );

  vpfx_fsm #(.PFX_W(PFX_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pfx_valid_i (pfx_valid_i),
    .src_legal_i (src_legal),
    .src_pfx_i   (src_pfx),
    .ins_valid_i (ins_valid_i),
    .ins_vec_i   (ins_vec_i),
    .ins_pfx_ok_i(ins_pfx_ok_i),
    .ins_done_i  (ins_done_i),
    .irq_i       (irq_i),
    .state_o     (state),
    .pfx_o       (pfx_o),
    .arm_o       (arm),
    .epc_load_o  (epc_load),
    .restart_o   (rst_stb),
    .exc_o       (exc_o),
    .exc_cause_o (exc_cause_o)
  );

  vpfx_ctx #(.PC_W(XLEN), .VSTART_W(VSTART_W)) u_ctx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .pc_i      (pfx_pc_i),
    .epc_load_i(epc_load),
    .restart_i (state == ST_ACTIVE && irq_i),
    .elem_idx_i(elem_idx_i),
    .epc_o     (epc_o),
    .vstart_o  (vstart_o)
  );

  assign restart_o = rst_stb;

  always_comb begin
    vtype_pfx_o = '0;
    vtype_pfx_o[PFX_MSB:PFX_LSB] = pfx_o;
  end
endmodule

// File: rtl/vpfx_ctrl_chk.sv
module vpfx_ctrl_chk
  import vpfx_pkg::*;
#(
  parameter int SRC_W    = 15,
  parameter int PFX_W    = 10,
  parameter int VSTART_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          state_i,
  input logic                pfx_valid_i,
  input logic [SRC_W-1:0]    pfx_src_i,
  input logic                ins_valid_i,
  input logic                ins_vec_i,
  input logic                ins_pfx_ok_i,
  input logic                ins_done_i,
  input logic                irq_i,
  input logic [VSTART_W-1:0] elem_idx_i,
  input logic [PFX_W-1:0]    pfx_o,
  input logic                exc_o,
  input logic [1:0]          exc_cause_o,
  input logic                restart_o,
  input logic [VSTART_W-1:0] vstart_o
);
  logic src_bad;
  assign src_bad = |pfx_src_i[SRC_W-1:PFX_W];

  // R2
  arm_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && pfx_valid_i && !src_bad) |=> pfx_o == $past(pfx_src_i[PFX_W-1:0]));

  // R3
  bad_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && pfx_valid_i && src_bad) |=> exc_o && exc_cause_o == CAUSE_SRC && pfx_o == '0);

  // R4
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ACTIVE && ins_done_i && !irq_i) |=> pfx_o == '0 && !exc_o && !restart_o);

  // R6
  unsup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ARMED && !pfx_valid_i && ins_valid_i && ins_vec_i && !ins_pfx_ok_i)
      |=> exc_o && exc_cause_o == CAUSE_UNSUP && pfx_o == '0);

  // R7
  irq_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ACTIVE && irq_i) |=> restart_o && vstart_o == $past(elem_idx_i) && pfx_o == '0);

  // R8
  vstart_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_o |-> vstart_o == $past(vstart_o));

  // R10
  excl_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_o && restart_o));

  // R10
  idle_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |-> exc_cause_o == CAUSE_NONE);
endmodule

bind vpfx_ctrl vpfx_ctrl_chk #(.SRC_W(SRC_W), .PFX_W(PFX_W), .VSTART_W(VSTART_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (state),
  .pfx_valid_i (pfx_valid_i),
  .pfx_src_i   (pfx_src_i),
  .ins_valid_i (ins_valid_i),
  .ins_vec_i   (ins_vec_i),
  .ins_pfx_ok_i(ins_pfx_ok_i),
  .ins_done_i  (ins_done_i),
  .irq_i       (irq_i),
  .elem_idx_i  (elem_idx_i),
  .pfx_o       (pfx_o),
  .exc_o       (exc_o),
  .exc_cause_o (exc_cause_o),
  .restart_o   (restart_o),
  .vstart_o    (vstart_o)
);

// File: tb/vpfx_ctrl_tb.sv
module vpfx_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pfx_valid_i = 0, ins_valid_i = 0, ins_vec_i = 0, ins_pfx_ok_i = 0;
  logic        ins_done_i = 0, irq_i = 0;
  logic [14:0] pfx_src_i = '0;
  logic [31:0] pfx_pc_i = '0;
  logic [15:0] elem_idx_i = '0;
  logic [9:0]  pfx_o;
  logic [31:0] vtype_pfx_o, epc_o;
  logic        exc_o, restart_o;
  logic [1:0]  exc_cause_o;
  logic [15:0] vstart_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference state: 0 idle, 1 armed, 2 active
  int          m_st = 0;
  logic [9:0]  m_pfx = '0;
  logic [31:0] m_pc = '0, m_epc = '0;
  logic [15:0] m_vs = '0;
  logic        m_exc = 0, m_rst = 0;
  logic [1:0]  m_cause = '0;

  vpfx_ctrl u_dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vtype_of(logic [9:0] p);
    return {1'b0, p, 21'b0};
  endfunction

  task automatic model_step();
    m_exc = 0; m_rst = 0; m_cause = 2'b00;
    case (m_st)
      0: if (pfx_valid_i) begin
           if (pfx_src_i[14:10] != 0) begin m_exc = 1; m_cause = 2'b01; end
           else begin m_st = 1; m_pfx = pfx_src_i[9:0]; m_pc = pfx_pc_i; end
         end
      1: if (pfx_valid_i || (ins_valid_i && !ins_vec_i)) begin
           m_exc = 1; m_cause = 2'b10; m_epc = m_pc; m_st = 0; m_pfx = '0;
         end else if (ins_valid_i && !ins_pfx_ok_i) begin
           m_exc = 1; m_cause = 2'b11; m_st = 0; m_pfx = '0;
         end else if (ins_valid_i) m_st = 2;
      default: if (irq_i) begin
           m_rst = 1; m_epc = m_pc; m_vs = elem_idx_i; m_st = 0; m_pfx = '0;
         end else if (ins_done_i) begin m_st = 0; m_pfx = '0; end
    endcase
  endtask

  task automatic cmp_all();
    chk("R4 pfx_o", 32'(pfx_o), 32'(m_pfx));
    chk("R2 vtype_pfx_o", vtype_pfx_o, vtype_of(m_pfx));
    chk("R10 exc_o", 32'(exc_o), 32'(m_exc));
    chk("R10 exc_cause_o", 32'(exc_cause_o), 32'(m_cause));
    chk("R7 restart_o", 32'(restart_o), 32'(m_rst));
    chk("R5 epc_o", epc_o, m_epc);
    chk("R8 vstart_o", 32'(vstart_o), 32'(m_vs));
  endtask

  // inputs are driven at a negedge; outputs are checked at the next negedge
  task automatic cycle();
    model_step();
    @(negedge clk_i);
    cmp_all();
  endtask

  task automatic clr_in();
    pfx_valid_i = 0; ins_valid_i = 0; ins_vec_i = 0; ins_pfx_ok_i = 0;
    ins_done_i = 0; irq_i = 0; pfx_src_i = '0;
  endtask

  task automatic arm(logic [9:0] p, logic [31:0] pc);
    clr_in(); pfx_valid_i = 1; pfx_src_i = {5'b0, p}; pfx_pc_i = pc;
    cycle(); clr_in();
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1 pfx_o", 32'(pfx_o), 0);
    chk("R1 vtype_pfx_o", vtype_pfx_o, 0);
    chk("R1 exc_o", 32'(exc_o), 0);
    chk("R1 restart_o", 32'(restart_o), 0);
    chk("R1 epc_o", epc_o, 0);
    chk("R1 vstart_o", 32'(vstart_o), 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2 legal prefix, R8 vstart untouched
    arm(10'h2A5, 32'h1000);
    chk("R2 pfx_o", 32'(pfx_o), 32'h2A5);
    chk("R2 vtype_pfx_o", vtype_pfx_o, 32'h54A0_0000);
    chk("R8 vstart_o", 32'(vstart_o), 0);
    // R9 irq/done ignored while armed
    irq_i = 1; ins_done_i = 1; elem_idx_i = 16'd9; cycle(); clr_in();
    chk("R9 armed pfx_o", 32'(pfx_o), 32'h2A5);
    chk("R9 armed restart_o", 32'(restart_o), 0);
    // R4 start, R9 prefix ignored while active
    ins_valid_i = 1; ins_vec_i = 1; ins_pfx_ok_i = 1; cycle(); clr_in();
    pfx_valid_i = 1; pfx_src_i = 15'h0111; ins_valid_i = 1; cycle(); clr_in();
    chk("R9 active pfx_o", 32'(pfx_o), 32'h2A5);
    chk("R9 active exc_o", 32'(exc_o), 0);
    ins_done_i = 1; cycle(); clr_in();
    chk("R4 done pfx_o", 32'(pfx_o), 0);

    // R3 bad source
    pfx_valid_i = 1; pfx_src_i = 15'h4003; pfx_pc_i = 32'h1500; cycle(); clr_in();
    chk("R3 exc_o", 32'(exc_o), 1);
    chk("R3 cause", 32'(exc_cause_o), 1);
    chk("R3 pfx_o", 32'(pfx_o), 0);
    cycle();
    chk("R10 exc strobe", 32'(exc_o), 0);

    // R5 scalar successor
    arm(10'h155, 32'h2000);
    ins_valid_i = 1; ins_vec_i = 0; cycle(); clr_in();
    chk("R5 cause", 32'(exc_cause_o), 2);
    chk("R5 epc_o", epc_o, 32'h2000);
    chk("R5 pfx_o", 32'(pfx_o), 0);
    // R5 second prefix
    arm(10'h0F0, 32'h3000);
    pfx_valid_i = 1; pfx_src_i = 15'h0001; pfx_pc_i = 32'h3004;
    ins_valid_i = 1; ins_vec_i = 1; ins_pfx_ok_i = 1; cycle(); clr_in();
    chk("R5 second cause", 32'(exc_cause_o), 2);
    chk("R5 second epc_o", epc_o, 32'h3000);

    // R6 unsupported target
    arm(10'h3FF, 32'h4000);
    ins_valid_i = 1; ins_vec_i = 1; ins_pfx_ok_i = 0; cycle(); clr_in();
    chk("R6 cause", 32'(exc_cause_o), 3);
    chk("R6 epc_o", epc_o, 32'h3000);
    chk("R6 pfx_o", 32'(pfx_o), 0);
    chk("R8 vstart_o after exc", 32'(vstart_o), 0);

    // R7 interrupt wins over done
    arm(10'h001, 32'h5000);
    ins_valid_i = 1; ins_vec_i = 1; ins_pfx_ok_i = 1; cycle(); clr_in();
    irq_i = 1; ins_done_i = 1; elem_idx_i = 16'd37; cycle(); clr_in();
    chk("R7 restart_o", 32'(restart_o), 1);
    chk("R7 epc_o", epc_o, 32'h5000);
    chk("R7 vstart_o", 32'(vstart_o), 37);
    chk("R7 pfx_o", 32'(pfx_o), 0);
    chk("R10 no exc on restart", 32'(exc_o), 0);
    cycle();
    chk("R10 restart strobe", 32'(restart_o), 0);

    // random traffic against the reference
    for (int i = 0; i < 4000; i++) begin
      pfx_valid_i  = ($urandom % 4) == 0;
      pfx_src_i    = (($urandom % 4) == 0) ? 15'($urandom) : {5'b0, 10'($urandom)};
      pfx_pc_i     = $urandom & 32'hFFFF_FFFC;
      ins_valid_i  = ($urandom % 3) == 0;
      ins_vec_i    = ($urandom % 5) != 0;
      ins_pfx_ok_i = ($urandom % 5) != 0;
      ins_done_i   = ($urandom % 4) == 0;
      irq_i        = ($urandom % 8) == 0;
      elem_idx_i   = 16'($urandom);
      cycle();
    end
    clr_in();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule